// File: doc/BRIEF.md
# Streaming 7×7 Binary Median and Dilation Filter

This block cleans up a 1-bit foreground mask as it streams past in raster order, at one pixel per clock. Each pixel is replaced by the majority vote of the 7×7 neighbourhood centred on it. Isolated specks disappear and small holes inside solid regions close up. An optional second stage with the same window then grows every surviving region by three pixels in all directions. The output is 1 wherever any pixel of the 7×7 neighbourhood in the majority-voted mask is set.

Each stage keeps six earlier lines of the mask in a line store and reads one 7-bit column per accepted pixel. It does not sort the window. Each stage keeps a running set-pixel count: it adds the popcount of the column that enters and subtracts the popcount of the column that falls out. At each line start the count begins again from zero. Window positions that fall outside the frame read as 0. This covers rows of the neighbouring frames, the wrap-around columns of the neighbouring lines, and everything beyond the four edges. Both stages use the same engine and differ only in the count threshold. Frames run back to back, so the last three rows of a frame leave a stage while the first rows of the next frame arrive.

Top module: `bmask_filter`

## Requirements
- R1: While rst_ni is low, and after its release until the first output, valid_o, pix_o, sof_o and eol_o are 0.
- R2: In the majority stage, the output for pixel (r,c) is 1 exactly when more than 24 of the 49 positions with row in r-3..r+3 and column in c-3..c+3 hold a 1. A count of exactly 24 gives 0.
- R3: Window positions with a row outside 0..HEIGHT-1 or a column outside 0..WIDTH-1 of the current frame count as 0. This holds even when adjacent lines or frames hold ones.
- R4: With DILATE_EN=1, the output for pixel (r,c) is the OR of the majority results over the 7×7 window around (r,c), with out-of-frame positions as 0. With DILATE_EN=0, the majority result is output directly.
- R5: In each stage, the result for a pixel leaves one clock after the stage accepts the input pixel 3·WIDTH+3 accepted pixels later in stream order. valid_o is 0 in the cycle after valid_i is 0.
- R6: sof_o is 1 exactly with the output pixel at row 0, column 0, and eol_o is 1 exactly with each output pixel in column WIDTH-1. Both are 1 only together with valid_o, and the first valid output after reset carries sof_o.
- R7: Pixels presented with valid_i before the first sof_i are dropped and produce no output.
- R8: Frames are exactly WIDTH×HEIGHT pixels, with sof_i on the first pixel and eol_i on the last pixel of every line. Cycles with valid_i low may appear anywhere and do not change any result. After N input pixels a stage has emitted N-(3·WIDTH+3) output pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel present this cycle |
| pix_i | input | 1 | Input mask pixel |
| sof_i | input | 1 | Input pixel is row 0, column 0 of a frame |
| eol_i | input | 1 | Input pixel is the last of its line |
| valid_o | output | 1 | Output pixel present this cycle |
| pix_o | output | 1 | Filtered mask pixel |
| sof_o | output | 1 | Output pixel is row 0, column 0 |
| eol_o | output | 1 | Output pixel is the last of its line |

## Verification
A frame of all ones isolates the border handling: corners see only 16 set positions and give 0, while edge-centred windows see 28 and give 1. A checkerboard puts 24 or 25 ones in every interior window, so it separates the strict majority threshold from an off-by-one compare. Random masks at 20 %, 50 % and 80 % density, with random idle cycles, exercise the running count across column exits and line restarts, and show whether gaps disturb the result. Trailing all-zero frames flush the last rows and confirm that neighbouring frames never leak into a window.

// File: rtl/bmask_pkg.sv
package bmask_pkg;
  localparam int WIN        = 7;
  localparam int HALF       = WIN / 2;
  localparam int CNT_W      = $clog2(WIN * WIN + 1);
  localparam int PC_W       = $clog2(WIN + 1);
  localparam int MEDIAN_THR = (WIN * WIN) / 2;

  typedef logic [WIN-1:0]   colv_t;
  typedef logic [PC_W-1:0]  pc_t;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/bmask_pos_track.sv
module bmask_pos_track
  import bmask_pkg::*;
#(
  parameter int WIDTH  = 640,
  parameter int HEIGHT = 480,
  localparam int COL_W = $clog2(WIDTH),
  localparam int ROW_W = $clog2(HEIGHT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eol_i,
  output logic             accept_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             primed_o,
  output logic             ctr_sof_o,
  output logic             ctr_eol_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(WIDTH - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(HEIGHT - 1);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             synced_q, primed_q;

  assign accept_o  = valid_i && (synced_q || sof_i);
  assign col_o     = sof_i ? '0 : col_q;
  assign row_o     = sof_i ? '0 : row_q;
  // centre pixel lags the input by HALF lines plus HALF pixels
  assign ctr_sof_o = (row_o == ROW_W'(HALF)) && (col_o == COL_W'(HALF));
  assign ctr_eol_o = (col_o == COL_W'(HALF - 1));
  assign primed_o  = primed_q || ctr_sof_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q    <= '0;
      row_q    <= '0;
      synced_q <= 1'b0;
      primed_q <= 1'b0;
    end else if (accept_o) begin
      synced_q <= 1'b1;
      if (ctr_sof_o) primed_q <= 1'b1;
      if (col_o == COL_LAST) begin
        col_q <= '0;
        row_q <= (row_o == ROW_LAST) ? '0 : row_o + 1'b1;
      end else begin
        col_q <= col_o + 1'b1;
        row_q <= row_o;
      end
    end
  end

  assert_eol_align_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && eol_i) |-> (col_o == COL_LAST));
endmodule

// File: rtl/bmask_line_store.sv
module bmask_line_store
  import bmask_pkg::*;
#(
  parameter int WIDTH  = 640,
  parameter int HEIGHT = 480,
  localparam int COL_W = $clog2(WIDTH),
  localparam int ROW_W = $clog2(HEIGHT)
) (
  input  logic             clk_i,
  input  logic             accept_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             pix_i,
  output colv_t            colv_o
);
  // bit k of a stored word holds row (current - 1 - k)
  logic [WIN-2:0] mem_q [WIDTH];
  logic [WIN-2:0] old;
  colv_t          raw;
  logic           upper;

  assign old   = mem_q[col_i];
  assign raw   = {old, pix_i};
  assign upper = (row_i >= ROW_W'(HALF));

  always_ff @(posedge clk_i) begin
    if (accept_i) mem_q[col_i] <= {old[WIN-3:0], pix_i};
  end

  // a row is kept only if it lies in the same frame as the target centre row
  for (genvar k = 0; k < WIN; k++) begin : g_mask
    assign colv_o[k] = raw[k] & (upper == (ROW_W'(k) <= row_i));
  end
endmodule

// File: rtl/bmask_win_count.sv
module bmask_win_count
  import bmask_pkg::*;
#(
  parameter int WIDTH  = 640,
  localparam int COL_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [COL_W-1:0] col_i,
  input  colv_t            colv_i,
  output cnt_t             cnt_o
);
  pc_t  pc_q [WIN];
  pc_t  pc_new, leave;
  cnt_t acc_q, acc_n, tail_q, tail_n;
  logic head;

  assign head = (col_i < COL_W'(HALF));

  always_comb begin
    pc_new = pc_t'($countones(colv_i));
    leave  = pc_q[WIN-1];
    if (col_i == '0)                acc_n = cnt_t'(pc_new);
    else if (col_i < COL_W'(WIN))   acc_n = acc_q + cnt_t'(pc_new);
    else                            acc_n = acc_q + cnt_t'(pc_new) - cnt_t'(leave);
    // right-border windows of the previous line shrink while the new line starts
    tail_n = ((col_i == '0) ? acc_q : tail_q) - cnt_t'(leave);
    cnt_o  = head ? tail_n : acc_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WIN; i++) pc_q[i] <= '0;
      acc_q  <= '0;
      tail_q <= '0;
    end else if (accept_i) begin
      pc_q[0] <= pc_new;
      for (int i = 1; i < WIN; i++) pc_q[i] <= pc_q[i-1];
      acc_q <= acc_n;
      if (head) tail_q <= tail_n;
    end
  end

  assert_count_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q <= cnt_t'(WIN * WIN)) && (tail_q <= cnt_t'(WIN * WIN)));
endmodule

// File: rtl/bmask_stage.sv
module bmask_stage
  import bmask_pkg::*;
#(
  parameter int WIDTH  = 640,
  parameter int HEIGHT = 480,
  parameter int THR    = MEDIAN_THR,
  localparam int COL_W = $clog2(WIDTH),
  localparam int ROW_W = $clog2(HEIGHT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic pix_i,
  input  logic sof_i,
  input  logic eol_i,
  output logic valid_o,
  output logic pix_o,
  output logic sof_o,
  output logic eol_o
);
  logic             accept, primed, ctr_sof, ctr_eol, emit, seen_q;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  colv_t            colv;
  cnt_t             cnt;

  bmask_pos_track #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_pos (
    .clk_i, .rst_ni, .valid_i, .sof_i, .eol_i,
    .accept_o(accept), .col_o(col), .row_o(row), .primed_o(primed),
    .ctr_sof_o(ctr_sof), .ctr_eol_o(ctr_eol)
  );

  bmask_line_store #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_lines (
    .clk_i, .accept_i(accept), .col_i(col), .row_i(row), .pix_i, .colv_o(colv)
  );

  bmask_win_count #(.WIDTH(WIDTH)) u_count (
    .clk_i, .rst_ni, .accept_i(accept), .col_i(col), .colv_i(colv), .cnt_o(cnt)
  );

  assign emit = accept && primed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= 1'b0;
      sof_o   <= 1'b0;
      eol_o   <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      valid_o <= emit;
      pix_o   <= emit && (cnt > cnt_t'(THR));
      sof_o   <= emit && ctr_sof;
      eol_o   <= emit && ctr_eol;
      if (valid_o) seen_q <= 1'b1;
    end
  end

  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_pix_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_o |-> valid_o);
  assert_mark_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o || eol_o) |-> valid_o);
  assert_first_sof_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !seen_q) |-> sof_o);
endmodule

// File: rtl/bmask_filter.sv
module bmask_filter
  import bmask_pkg::*;
#(
  parameter int WIDTH     = 640,
  parameter int HEIGHT    = 480,
  parameter bit DILATE_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic pix_i,
  input  logic sof_i,
  input  logic eol_i,
  output logic valid_o,
  output logic pix_o,
  output logic sof_o,
  output logic eol_o
);
  logic m_valid, m_pix, m_sof, m_eol;

  bmask_stage #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .THR(MEDIAN_THR)) u_median (
    .clk_i, .rst_ni, .valid_i, .pix_i, .sof_i, .eol_i,
    .valid_o(m_valid), .pix_o(m_pix), .sof_o(m_sof), .eol_o(m_eol)
  );

  if (DILATE_EN) begin : g_dilate
    // any set pixel in the window: count above zero
    bmask_stage #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .THR(0)) u_dilate (
      .clk_i, .rst_ni,
      .valid_i(m_valid), .pix_i(m_pix), .sof_i(m_sof), .eol_i(m_eol),
      .valid_o, .pix_o, .sof_o, .eol_o
    );
  end else begin : g_bypass
    assign valid_o = m_valid;
    assign pix_o   = m_pix;
    assign sof_o   = m_sof;
    assign eol_o   = m_eol;
  end
endmodule

// File: tb/tb_bmask_filter.sv
module tb_bmask_filter;
  localparam int W   = 16;
  localparam int H   = 10;
  localparam int NF  = 7;
  localparam int LAT = 3 * W + 3;
  localparam int FPX = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, pix_i = 1'b0, sof_i = 1'b0, eol_i = 1'b0;
  logic d_valid, d_pix, d_sof, d_eol;
  logic m_valid, m_pix, m_sof, m_eol;

  always #4 clk = ~clk;

  bmask_filter #(.WIDTH(W), .HEIGHT(H), .DILATE_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .pix_i, .sof_i, .eol_i,
    .valid_o(d_valid), .pix_o(d_pix), .sof_o(d_sof), .eol_o(d_eol)
  );
  bmask_filter #(.WIDTH(W), .HEIGHT(H), .DILATE_EN(1'b0)) dut_med (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .pix_i, .sof_i, .eol_i,
    .valid_o(m_valid), .pix_o(m_pix), .sof_o(m_sof), .eol_o(m_eol)
  );

  bit frm [NF][H][W];
  bit med [NF][H][W];
  bit dil [NF][H][W];
  int n_chk = 0, n_fail = 0;
  int idx_m = 0, idx_d = 0, nacc = 0;
  bit bsync = 0, exp_vm = 0, gaps = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int win_sum(int f, int r, int c, bit use_med);
    int s = 0;
    for (int dr = -3; dr <= 3; dr++)
      for (int dc = -3; dc <= 3; dc++)
        if (r+dr >= 0 && r+dr < H && c+dc >= 0 && c+dc < W)
          s += use_med ? int'(med[f][r+dr][c+dc]) : int'(frm[f][r+dr][c+dc]);
    return s;
  endfunction

  // expected single-stage valid timing (R5, R7)
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_vm <= 1'b0;
    end else begin
      automatic bit a = valid_i && (bsync || sof_i);
      exp_vm <= a && (nacc >= LAT);
      if (a) begin
        nacc  <= nacc + 1;
        bsync <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_valid == exp_vm, "R5 valid timing", m_valid, exp_vm);
      if (m_valid) begin
        automatic int f = idx_m / FPX;
        automatic int r = (idx_m % FPX) / W;
        automatic int c = idx_m % W;
        if (f < NF) begin
          chk(m_pix == med[f][r][c], "R2/R3 majority pixel", m_pix, med[f][r][c]);
          chk(m_sof == (r == 0 && c == 0), "R6 sof_o", m_sof, (r == 0 && c == 0));
          chk(m_eol == (c == W-1), "R6 eol_o", m_eol, (c == W-1));
        end
        idx_m++;
      end
      if (d_valid) begin
        automatic int f = idx_d / FPX;
        automatic int r = (idx_d % FPX) / W;
        automatic int c = idx_d % W;
        if (f < NF) begin
          chk(d_pix == dil[f][r][c], "R4 dilated pixel", d_pix, dil[f][r][c]);
          chk(d_sof == (r == 0 && c == 0), "R6 sof_o dilated", d_sof, (r == 0 && c == 0));
          chk(d_eol == (c == W-1), "R6 eol_o dilated", d_eol, (c == W-1));
        end
        idx_d++;
      end
    end
  end

  task automatic drive(bit v, bit p, bit s, bit e);
    @(posedge clk); #1;
    valid_i = v; pix_i = p; sof_i = s; eol_i = e;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++)
          case (f)
            0: frm[f][r][c] = 1'b1;
            1: frm[f][r][c] = bit'((r + c) % 2);
            2: frm[f][r][c] = bit'($urandom % 2);
            3: frm[f][r][c] = ($urandom % 10) < 2;
            4: frm[f][r][c] = ($urandom % 10) < 8;
            default: frm[f][r][c] = 1'b0;
          endcase
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) med[f][r][c] = win_sum(f, r, c, 1'b0) > 24;
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) dil[f][r][c] = win_sum(f, r, c, 1'b1) > 0;

    // directed border values of the all-ones frame (R3)
    chk(med[0][0][0] == 1'b0, "R3 corner ref", med[0][0][0], 0);
    chk(med[0][0][5] == 1'b1, "R3 edge ref", med[0][0][5], 1);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_valid == 0 && d_valid == 0, "R1 reset valid", m_valid | d_valid, 0);
    chk(m_pix == 0 && d_pix == 0 && m_sof == 0 && d_eol == 0, "R1 reset data", m_pix | d_pix, 0);
    rst_n = 1'b1;

    // pixels before any start-of-frame must be dropped
    for (int i = 0; i < 20; i++) drive(1'b1, bit'($urandom % 2), 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(m_valid == 0 && d_valid == 0, "R7 pre-sof ignored", m_valid | d_valid, 0);

    for (int f = 0; f < NF; f++) begin
      gaps = (f >= 2);
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) begin
          if (gaps && ($urandom % 4) == 0) drive(1'b0, 1'b0, 1'b0, 1'b0);
          drive(1'b1, frm[f][r][c], (r == 0 && c == 0), (c == W-1));
        end
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (20) @(posedge clk);
    @(negedge clk);

    chk(idx_m == NF*FPX - LAT, "R8 majority output count", idx_m, NF*FPX - LAT);
    chk(idx_d == NF*FPX - 2*LAT, "R8 dilated output count", idx_d, NF*FPX - 2*LAT);
    summary();
    $finish;
  end
endmodule